// File: doc/BRIEF.md
# Configurable I/O Pin Resource Router

The block sits between twelve general digital pads and a handful of on-chip consumers. Each pad has a 3-bit selector that ties it to one consumer. The consumers are:

- two interrupt request lines, high priority and low priority, each of which a pin can trigger on a rising or a falling edge;
- the clock inputs of two counters.

When several pins pick the same consumer, their contributions are merged by OR. A pin whose selector is zero acts as plain I/O. For such a pin, a per-pin direction bit drives the pad output-enable. Any routed pin is held as an input.

Every pin input passes through a two-flop synchroniser, and edges are detected on the synchronised level. Interrupt requests are registered pulses one clock wide. Counter clocks are the ORed synchronised levels, so the counters downstream can find the edges themselves. Configuration arrives through a simple byte-wide write port. Two pin selectors are packed per byte. The direction bits occupy two further bytes.

Top module: `pin_router`

## Requirements
- R1: A write with `wr_addr` = k, for k from 0 to 5, loads the selector of pin 2k from `wr_data[2:0]` and the selector of pin 2k+1 from `wr_data[6:4]`; bits 3 and 7 are ignored. Address 6 loads the direction bits of pins 0-7 from `wr_data[7:0]`. Address 7 loads pins 8-11 from `wr_data[3:0]` and ignores `wr_data[7:4]`. Writes to addresses 8-15 change nothing.
- R2: Selector codes are:
  - 0: plain I/O
  - 1: reserved
  - 2: counter-0 clock
  - 3: counter-1 clock
  - 4: high-priority interrupt on a falling edge
  - 5: high-priority interrupt on a rising edge
  - 6: low-priority interrupt on a falling edge
  - 7: low-priority interrupt on a rising edge
- R3: A pin level applied before clock edge k reaches the counter clock outputs after edge k+1, not earlier, through two synchronising flops.
- R4: `cnt0_clk` is the OR of the synchronised levels of all pins with code 2, and `cnt1_clk` is the same for code 3.
- R5: `hi_irq` is high for exactly one cycle after edge k+2 when any pin with code 4 falls, or any pin with code 5 rises, at its input before edge k. Simultaneous edges on several such pins give one pulse.
- R6: `lo_irq` behaves the same way for codes 6 (falling) and 7 (rising).
- R7: An edge of the polarity that a pin did not select raises no interrupt.
- R8: `pin_oe[i]` equals direction bit i (1 = output) when pin i has code 0, and is 0 for any other code.
- R9: A pin with code 1, or with code 0, affects neither interrupt nor either counter clock.
- R10: Synchronous reset clears all selectors and direction bits. After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 4 | Configuration register index |
| wr_data | input | 8 | Configuration write data |
| pin_in | input | 12 | Asynchronous pad input levels |
| pin_oe | output | 12 | Pad output-enable per pin |
| hi_irq | output | 1 | High-priority interrupt pulse |
| lo_irq | output | 1 | Low-priority interrupt pulse |
| cnt0_clk | output | 1 | Counter-0 clock level |
| cnt1_clk | output | 1 | Counter-1 clock level |

## Verification
The bench builds the router with its defaults: twelve pins, two synchroniser stages, a 4-bit index and byte data. These defaults bring several cases within reach:

- unused indices 8 to 15 and the half-filled direction byte for pins 8-11;
- both halves of a selector byte, on even and odd pins;
- OR merging between pins that lie in different selector bytes.

Because the synchroniser depth is two, the exact cycles in which counter levels and interrupt pulses first appear can be checked directly.

// File: rtl/pin_router_pkg.sv
package pin_router_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        RES_GPIO    = 3'd0,
        RES_RSVD    = 3'd1,
        RES_CNT0    = 3'd2,
        RES_CNT1    = 3'd3,
        RES_HI_FALL = 3'd4,
        RES_HI_RISE = 3'd5,
        RES_LO_FALL = 3'd6,
        RES_LO_RISE = 3'd7
    } res_sel_e;

    typedef struct packed {
        logic hi_irq;
        logic lo_irq;
        logic cnt0;
        logic cnt1;
    } route_out_t;

    // True when a pin configured for rise_code or fall_code shows that edge
    function automatic logic edge_hit(res_sel_e sel, res_sel_e rise_code,
                                      res_sel_e fall_code, logic lvl, logic prev);
        return ((sel == rise_code) && lvl && !prev) ||
               ((sel == fall_code) && !lvl && prev);
    endfunction

endpackage

// File: rtl/pin_cfg_regs.sv
module pin_cfg_regs
    import pin_router_pkg::*;
#(
    parameter int N_PINS = 12,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output res_sel_e [N_PINS-1:0]         sel_o,
    output logic [N_PINS-1:0]             dir_o
);
    localparam int PINS_PER_REG = 2;
    localparam int FIELD_STRIDE = DATA_W / PINS_PER_REG;
    localparam int SEL_REGS     = (N_PINS + PINS_PER_REG - 1) / PINS_PER_REG;
    localparam int DIR_BASE     = SEL_REGS;

    res_sel_e [N_PINS-1:0] sel_q;
    logic [N_PINS-1:0]     dir_q;

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        localparam int SREG = p / PINS_PER_REG;
        localparam int SLSB = (p % PINS_PER_REG) * FIELD_STRIDE;
        localparam int DREG = DIR_BASE + p / DATA_W;
        localparam int DBIT = p % DATA_W;

        always_ff @(posedge clk) begin
            if (rst) begin
                sel_q[p] <= RES_GPIO;
            end else if (wr_en && wr_addr == ADDR_W'(SREG)) begin
                sel_q[p] <= res_sel_e'(wr_data[SLSB +: SEL_W]);
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                dir_q[p] <= 1'b0;
            end else if (wr_en && wr_addr == ADDR_W'(DREG)) begin
                dir_q[p] <= wr_data[DBIT];
            end
        end

        // R1
        sel_wr_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == ADDR_W'(SREG)) |=> (sel_q[p] == $past(wr_data[SLSB +: SEL_W])));

        // R1
        dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!wr_en || wr_addr != ADDR_W'(DREG)) |=> $stable(dir_q[p]));

        // R10
        rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> (sel_q[p] == RES_GPIO && !dir_q[p]));
    end

    assign sel_o = sel_q;
    assign dir_o = dir_q;

endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int N_PINS = 12,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] lvl_o,
    output logic [N_PINS-1:0] prev_o
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0][N_PINS-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= '0;
        else     chain_q[0] <= pin_i;
    end

    for (genvar s = 1; s < CHAIN; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[s] <= '0;
            else     chain_q[s] <= chain_q[s-1];
        end
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];

endmodule

// File: rtl/pin_route.sv
module pin_route
    import pin_router_pkg::*;
#(
    parameter int N_PINS = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  res_sel_e [N_PINS-1:0] sel_i,
    input  logic [N_PINS-1:0]     dir_i,
    input  logic [N_PINS-1:0]     lvl_i,
    input  logic [N_PINS-1:0]     prev_i,
    output route_out_t            res_o,
    output logic [N_PINS-1:0]     oe_o
);
    logic hit_hi, hit_lo, cnt0_c, cnt1_c;
    logic hi_q, lo_q;

    always_comb begin
        hit_hi = 1'b0;
        hit_lo = 1'b0;
        cnt0_c = 1'b0;
        cnt1_c = 1'b0;
        for (int p = 0; p < N_PINS; p++) begin
            hit_hi = hit_hi | edge_hit(sel_i[p], RES_HI_RISE, RES_HI_FALL, lvl_i[p], prev_i[p]);
            hit_lo = hit_lo | edge_hit(sel_i[p], RES_LO_RISE, RES_LO_FALL, lvl_i[p], prev_i[p]);
            cnt0_c = cnt0_c | ((sel_i[p] == RES_CNT0) & lvl_i[p]);
            cnt1_c = cnt1_c | ((sel_i[p] == RES_CNT1) & lvl_i[p]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            hi_q <= hit_hi;
            lo_q <= hit_lo;
        end
    end

    for (genvar p = 0; p < N_PINS; p++) begin : g_oe
        assign oe_o[p] = dir_i[p] && (sel_i[p] == RES_GPIO);
    end

    always_comb begin
        res_o.hi_irq = hi_q;
        res_o.lo_irq = lo_q;
        res_o.cnt0   = cnt0_c;
        res_o.cnt1   = cnt1_c;
    end

    // R5
    hi_src_chk: assert property (@(posedge clk) disable iff (rst)
        res_o.hi_irq |-> $past(|(lvl_i ^ prev_i)));

    // R6
    lo_src_chk: assert property (@(posedge clk) disable iff (rst)
        res_o.lo_irq |-> $past(|(lvl_i ^ prev_i)));

    // R4
    cnt0_lvl_chk: assert property (@(posedge clk) disable iff (rst)
        res_o.cnt0 |-> (|lvl_i));

    // R4
    cnt1_lvl_chk: assert property (@(posedge clk) disable iff (rst)
        res_o.cnt1 |-> (|lvl_i));

endmodule

// File: rtl/pin_router.sv
module pin_router
    import pin_router_pkg::*;
#(
    parameter int N_PINS      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_oe,
    output logic              hi_irq,
    output logic              lo_irq,
    output logic              cnt0_clk,
    output logic              cnt1_clk
);
    res_sel_e [N_PINS-1:0] sel;
    logic [N_PINS-1:0]     dir;
    logic [N_PINS-1:0]     lvl, prev;
    route_out_t            res;

    pin_cfg_regs #(.N_PINS(N_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) cfg_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sel_o(sel), .dir_o(dir)
    );

    pin_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .pin_i(pin_in), .lvl_o(lvl), .prev_o(prev)
    );

    pin_route #(.N_PINS(N_PINS)) route_i (
        .clk(clk), .rst(rst), .sel_i(sel), .dir_i(dir), .lvl_i(lvl),
        .prev_i(prev), .res_o(res), .oe_o(pin_oe)
    );

    assign hi_irq   = res.hi_irq;
    assign lo_irq   = res.lo_irq;
    assign cnt0_clk = res.cnt0;
    assign cnt1_clk = res.cnt1;

    for (genvar p = 0; p < N_PINS; p++) begin : g_chk
        // R8
        routed_input_chk: assert property (@(posedge clk) disable iff (rst)
            (sel[p] != RES_GPIO) |-> !pin_oe[p]);
    end

endmodule

// File: tb/pin_router_tb_top.sv
`timescale 1ns/1ps
module pin_router_tb_top;
    localparam int NV = 10;

    // {sel(36, octal digit i = pin i), dir(12), pins_a(12), pins_b(12), exp{hi,lo,c0,c1}(4), exp_oe(12)}
    localparam logic [87:0] VEC [NV] = '{
        {36'o000000000000, 12'hFFF, 12'h000, 12'hFFF, 4'b0000, 12'hFFF},
        {36'o000000000005, 12'hFFF, 12'h000, 12'h001, 4'b1000, 12'hFFE},
        {36'o000000004000, 12'h000, 12'h008, 12'h000, 4'b1000, 12'h000},
        {36'o000000004000, 12'h000, 12'h000, 12'h008, 4'b0000, 12'h000},
        {36'o000006700000, 12'hFFF, 12'h040, 12'h020, 4'b0100, 12'hF9F},
        {36'o020000000020, 12'h000, 12'h000, 12'h400, 4'b0010, 12'h000},
        {36'o300000000100, 12'hFFF, 12'h000, 12'h804, 4'b0001, 12'h7FB},
        {36'o000000000100, 12'h004, 12'h000, 12'h004, 4'b0000, 12'h000},
        {36'o000000000045, 12'hFFF, 12'h002, 12'h001, 4'b1000, 12'hFFC},
        {36'o020000000020, 12'h000, 12'h400, 12'h000, 4'b0000, 12'h000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [11:0] pin_in = '0;
    logic [11:0] pin_oe;
    logic        hi_irq, lo_irq, cnt0_clk, cnt1_clk;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pin_router dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pin_in(pin_in), .pin_oe(pin_oe), .hi_irq(hi_irq), .lo_irq(lo_irq),
        .cnt0_clk(cnt0_clk), .cnt1_clk(cnt1_clk)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg_all(input logic [35:0] s, input logic [11:0] d);
        for (int k = 0; k < 6; k++)
            wr(4'(k), {1'b0, s[6*k+3 +: 3], 1'b0, s[6*k +: 3]});
        wr(4'd6, d[7:0]);
        wr(4'd7, {4'h0, d[11:8]});
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8ns * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cycles(3);
        rst = 1'b0;
        cycles(1);
        // R10 reset state
        chk("R10 oe after reset", 32'(pin_oe), 32'h0);
        chk("R10 outputs after reset", {28'h0, hi_irq, lo_irq, cnt0_clk, cnt1_clk}, 32'h0);

        // Vector table: R2 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            logic [87:0] e;
            e = VEC[v];
            cfg_all(e[87:52], e[51:40]);
            pin_in = e[39:28];
            cycles(5);
            pin_in = e[27:16];
            @(posedge clk); @(posedge clk); @(negedge clk);
            chk($sformatf("R4 R9 cnt0 vec %0d", v), 32'(cnt0_clk), 32'(e[13]));
            chk($sformatf("R4 R9 cnt1 vec %0d", v), 32'(cnt1_clk), 32'(e[12]));
            @(posedge clk); @(negedge clk);
            chk($sformatf("R5 R7 hi_irq vec %0d", v), 32'(hi_irq), 32'(e[15]));
            chk($sformatf("R6 R7 lo_irq vec %0d", v), 32'(lo_irq), 32'(e[14]));
            chk($sformatf("R8 oe vec %0d", v), 32'(pin_oe), 32'(e[11:0]));
            @(negedge clk);
            chk($sformatf("R5 R6 pulse width vec %0d", v), {30'h0, hi_irq, lo_irq}, 32'h0);
        end

        // R1 register packing and ignored bits / addresses
        cfg_all(36'o0, 12'h000);
        pin_in = '0;
        wr(4'd6, 8'hFF);
        wr(4'd7, 8'hFF);
        cycles(1);
        chk("R1 dir bytes", 32'(pin_oe), 32'hFFF);
        wr(4'd0, 8'h88);
        wr(4'd8, 8'h00);
        wr(4'd15, 8'h77);
        cycles(1);
        chk("R1 ignored bits and addresses", 32'(pin_oe), 32'hFFF);
        wr(4'd5, 8'h30);
        cycles(1);
        chk("R1 odd pin field of index 5", 32'(pin_oe), 32'h7FF);

        // R3 synchroniser latency on pin 4 routed to counter 0
        wr(4'd2, 8'h02);
        cycles(3);
        pin_in = 12'h010;
        @(posedge clk); @(negedge clk);
        chk("R3 cnt0 not yet after one edge", 32'(cnt0_clk), 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R3 cnt0 after second edge", 32'(cnt0_clk), 32'h1);

        // R10 mid-run reset clears configuration
        rst = 1'b1;
        cycles(1);
        rst = 1'b0;
        cycles(1);
        chk("R10 oe after mid-run reset", 32'(pin_oe), 32'h0);
        pin_in = 12'h000;
        cycles(3);
        pin_in = 12'h010;
        cycles(4);
        chk("R10 selector cleared", {30'h0, cnt0_clk, hi_irq}, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule